// File: doc/BRIEF.md
# Processor Clock Ratio Generator

This block derives four related processor-domain clock enables from one chosen reference. Three reference inputs arrive as single-cycle enable pulses in a fast system clock domain. A two-bit source field selects one of them. A one-based six-bit divisor then thins the selected stream into a divided base rate. A ratio network counts base ticks and produces four outputs: the top rate, a half-rate output, a third output and a fourth output. The third output runs at one third or one half of the base rate, and the fourth at one sixth or one quarter. A separate one-bit ratio mode register selects the 6:3:2:1 or the 4:2:2:1 set.

Software programs a control word and the mode register through a simple write/read port. A changed source, divisor or mode does not act at once. It is held pending until the next divided-base boundary. At that boundary the divider and all ratio counters restart together, so the derived outputs stay phase-aligned with the top output. Each output has its own enable bit. A disabled output stays low while the counters behind it keep running.

Top module: `cpu_ratio_clkgen`

## Requirements
- R1: Control bits [5:4] select the reference. Codes 0 and 1 both take `ref_pulse[0]`, code 2 takes `ref_pulse[1]` and code 3 takes `ref_pulse[2]`.
- R2: Control bits [13:8] hold a one-based divisor N, so output 0 pulses once per N selected reference pulses. A value of 0 is accepted and behaves as N=1.
- R3: Output 1 pulses at exactly half the rate of the divided base.
- R4: Output 2 divides the base by 2+M, where M is bit 0 of the mode register (write/read address 1).
- R5: Output 3 divides the base by 4+2M, which gives ratios of 6:3:2:1 with M=1 and 4:2:2:1 with M=0.
- R6: Control bits 24, 25, 26 and 27 enable outputs 0, 1, 2 and 3 in that order. A disabled output stays low.
- R7: Reset sets the control register to 0x04000000, which enables only output 2, and sets the mode bit to 1.
- R8: Every output is a one-cycle pulse, and a derived output pulses only in a cycle in which the divided base also ticks.
- R9: A new source, divisor or mode takes effect at the next base boundary. After that boundary the first base tick comes a new divisor's worth of reference pulses later and fires all four outputs together.
- R10: Address 0 reads back only the defined control fields, with all other bits 0. Address 1 reads the mode bit in bit 0, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_pulse | input | 3 | Reference enable pulses, one per PLL |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 control, 1 mode |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read target: 0 control, 1 mode |
| rd_data | output | 32 | Read data (combinational) |
| tick_out | output | 4 | Output enable pulses: top, second, third, fourth |

## Verification
The hardest case to reach from the ports is the handover at a base boundary. The old settings must produce their last tick, and the counters must then restart so that the first tick under the new settings is a full four-output pulse at the new spacing. The bench runs with all outputs enabled and a known divisor, then rewrites only the divisor. It waits for the boundary pulse and measures the gap to the next top pulse, checking both its length and the fact that all four outputs fire in it. Rate checks count pulses over windows that are whole multiples of the longest output period, so each count is exact whatever the phase at which the window starts.

// File: rtl/cpu_ratio_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, field positions and the active-settings type
// for the processor clock ratio generator.
package cpu_ratio_pkg;
    localparam int DATA_W  = 32;
    localparam int NUM_REF = 3;
    localparam int NUM_OUT = 4;
    localparam int SEL_W   = 2;
    localparam int DIV_W   = 6;
    localparam int RCNT_W  = 3;
    // Control word field positions (software-visible layout).
    localparam int SRC_LSB = 4;
    localparam int DIV_LSB = 8;
    localparam int EN_LSB  = 24;
    // Reset value of the enable field: only the third output runs.
    localparam logic [NUM_OUT-1:0] EN_RST = 4'b0100;

    // Settings currently steering the datapath.
    typedef struct packed {
        logic [SEL_W-1:0] src;
        logic [DIV_W-1:0] div;
        logic             mode;
    } cfg_t;
endpackage

// File: rtl/crg_src_mux.sv
`timescale 1ns/1ps
// crg_src_mux: picks one reference pulse stream from a select code.
// Code 0 and code 1 alias to reference 0. Code k>=1 picks reference k-1.
// Assumes NUM_REF >= 2**SEL_W - 1.
module crg_src_mux
    import cpu_ratio_pkg::*;
(
    input  logic [NUM_REF-1:0] ref_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               ref_o
);
    logic [SEL_W-1:0] idx;

    // Fold the two low codes onto the first reference.
    always_comb begin
        idx   = (sel_i == '0) ? '0 : sel_i - 1'b1;
        ref_o = ref_i[idx];
    end
endmodule

// File: rtl/crg_ref_divider.sv
`timescale 1ns/1ps
// crg_ref_divider: counts selected reference pulses and emits a base tick
// on every lim_i-th pulse. The tick is combinational in the pulse cycle.
// Assumes lim_i is in 1..2**DIV_W-1 (the caller maps a zero field to 1).
module crg_ref_divider
    import cpu_ratio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_i,
    input  logic [DIV_W-1:0] lim_i,
    output logic             base_o,
    output logic [DIV_W-1:0] cnt_o
);
    logic [DIV_W-1:0] cnt_q;

    // The base tick is the reference pulse that completes a count.
    assign base_o = ref_i && (cnt_q == lim_i - 1'b1);
    assign cnt_o  = cnt_q;

    // Advance on each reference pulse and wrap on the base tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (base_o) cnt_q <= '0;
        else if (ref_i)  cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/crg_ratio_net.sv
`timescale 1ns/1ps
// crg_ratio_net: derives the four ratio fires from the base tick.
// Fire 0 follows the base tick. Fires 1..3 divide the base by 2, 2+M and
// 4+2M. Every derived counter restarts on restart_i so that all outputs
// realign with the next base tick.
module crg_ratio_net
    import cpu_ratio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               base_i,
    input  logic               restart_i,
    input  logic               mode_i,
    output logic [NUM_OUT-1:0] fire_o
);
    assign fire_o[0] = base_i;

    for (genvar k = 1; k < NUM_OUT; k++) begin : g_ratio
        logic [RCNT_W-1:0] cnt_q;
        logic [RCNT_W-1:0] modulus;

        // Pick this stage's divide ratio from its position and the mode.
        always_comb begin
            case (k)
                1:       modulus = 3'd2;
                2:       modulus = mode_i ? 3'd3 : 3'd2;
                default: modulus = mode_i ? 3'd6 : 3'd4;
            endcase
        end

        // Fire on the base tick that finds the counter at its origin.
        assign fire_o[k] = base_i && (cnt_q == '0);

        // Count base ticks modulo the ratio; a restart wins over counting.
        always_ff @(posedge clk) begin
            if (!rst_n)         cnt_q <= '0;
            else if (restart_i) cnt_q <= '0;
            else if (base_i)    cnt_q <= (cnt_q == modulus - 1'b1) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cpu_ratio_clkgen.sv
`timescale 1ns/1ps
// cpu_ratio_clkgen: top of the processor clock ratio generator.
// It holds the control and mode registers, applies pending settings at
// a base boundary, and registers the gated output pulses.
// Assumes every input is synchronous to clk and each reference arrives
// as a one-cycle enable.
module cpu_ratio_clkgen
    import cpu_ratio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REF-1:0] ref_pulse,
    input  logic               wr_en,
    input  logic               wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic [NUM_OUT-1:0] tick_out
);
    logic [SEL_W-1:0]   src_q;
    logic [DIV_W-1:0]   div_q;
    logic [NUM_OUT-1:0] en_q;
    logic               mode_q;
    cfg_t               prog;
    cfg_t               act_q;
    logic               ref_sel;
    logic               base_tick;
    logic               apply;
    logic [DIV_W-1:0]   div_lim;
    logic [DIV_W-1:0]   div_cnt;
    logic [NUM_OUT-1:0] fire;

    // Software-visible registers: control fields and the ratio mode bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            div_q  <= '0;
            en_q   <= EN_RST;
            mode_q <= 1'b1;
        end else if (wr_en && !wr_addr) begin
            src_q <= wr_data[SRC_LSB +: SEL_W];
            div_q <= wr_data[DIV_LSB +: DIV_W];
            en_q  <= wr_data[EN_LSB +: NUM_OUT];
        end else if (wr_en && wr_addr) begin
            mode_q <= wr_data[0];
        end
    end

    // Readback places only the defined fields; all other bits read 0.
    always_comb begin
        rd_data = '0;
        if (rd_addr) begin
            rd_data[0] = mode_q;
        end else begin
            rd_data[SRC_LSB +: SEL_W]  = src_q;
            rd_data[DIV_LSB +: DIV_W]  = div_q;
            rd_data[EN_LSB +: NUM_OUT] = en_q;
        end
    end

    // Programmed settings, compared against those in use.
    assign prog    = '{src: src_q, div: div_q, mode: mode_q};
    assign apply   = base_tick && (prog != act_q);
    assign div_lim = (act_q.div == '0) ? DIV_W'(1) : act_q.div;

    // Adopt pending settings only at a base boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)     act_q <= '{src: '0, div: '0, mode: 1'b1};
        else if (apply) act_q <= prog;
    end

    crg_src_mux u_mux (
        .ref_i (ref_pulse),
        .sel_i (act_q.src),
        .ref_o (ref_sel)
    );

    crg_ref_divider u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_i  (ref_sel),
        .lim_i  (div_lim),
        .base_o (base_tick),
        .cnt_o  (div_cnt)
    );

    crg_ratio_net u_ratio (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_i    (base_tick),
        .restart_i (apply),
        .mode_i    (act_q.mode),
        .fire_o    (fire)
    );

    // Register the gated fires as one-cycle output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_out <= '0;
        else        tick_out <= fire & en_q;
    end
endmodule

// File: rtl/cpu_ratio_clkgen_chk.sv
`timescale 1ns/1ps
// cpu_ratio_clkgen_chk: property checker bound into cpu_ratio_clkgen.
// It observes ports and the signals passed between the sub-blocks.
module cpu_ratio_clkgen_chk
    import cpu_ratio_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_OUT-1:0] tick_out,
    input logic [NUM_OUT-1:0] en_q,
    input logic               base_tick,
    input logic               ref_sel,
    input logic [DIV_W-1:0]   div_cnt,
    input logic [DIV_W-1:0]   div_lim,
    input logic               apply,
    input logic               rd_addr,
    input logic [DATA_W-1:0]  rd_data
);
    // No output pulses unless its enable was set when the pulse was formed.
    assert_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_out != '0) |-> ((tick_out & ~$past(en_q)) == '0));

    // Derived outputs fire only on a base tick.
    assert_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_out[NUM_OUT-1:1] != '0) |-> $past(base_tick));

    // The base tick is always carried by the selected reference.
    assert_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
        base_tick |-> ref_sel);

    // The divider count stays below the active limit.
    assert_divcnt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt < div_lim);

    // Applying new settings leaves the divider at its origin.
    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> (div_cnt == '0));

    // The mode readback carries only bit 0.
    assert_mode_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr |-> (rd_data[DATA_W-1:1] == '0));
endmodule

bind cpu_ratio_clkgen cpu_ratio_clkgen_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_out  (tick_out),
    .en_q      (en_q),
    .base_tick (base_tick),
    .ref_sel   (ref_sel),
    .div_cnt   (div_cnt),
    .div_lim   (div_lim),
    .apply     (apply),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
);

// File: tb/test_cpu_ratio_clkgen.sv
`timescale 1ns/1ps
// Bench for cpu_ratio_clkgen. Reference 0 pulses every cycle, reference 1
// every 2nd cycle and reference 2 every 3rd cycle. Pulse counts are taken
// over windows of 24 base periods.
module test_cpu_ratio_clkgen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ref_pulse = '0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_addr = 1'b0;
    logic [31:0] rd_data;
    logic [3:0]  tick_out;
    int          errors = 0;
    int          checks = 0;
    longint      cyc = 0;
    bit          done = 1'b0;

    cpu_ratio_clkgen i_cpu_ratio_clkgen (
        .clk (clk), .rst_n (rst_n), .ref_pulse (ref_pulse),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .rd_addr (rd_addr), .rd_data (rd_data), .tick_out (tick_out)
    );

    always #4 clk = ~clk;

    // Reference pulse patterns, changed away from the active edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        ref_pulse = {cyc % 3 == 0, cyc % 2 == 0, 1'b1};
    end

    typedef struct packed {
        logic [1:0] src;
        logic [5:0] div;
        logic [3:0] en;
        logic       mode;
        logic [7:0] e0;
        logic [7:0] e1;
        logic [7:0] e2;
        logic [7:0] e3;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 6'd3,  4'hF, 1'b1, 8'd24, 8'd12, 8'd8,  8'd4},
        '{2'd1, 6'd3,  4'hF, 1'b0, 8'd24, 8'd12, 8'd12, 8'd6},
        '{2'd2, 6'd2,  4'hF, 1'b1, 8'd24, 8'd12, 8'd8,  8'd4},
        '{2'd3, 6'd1,  4'hF, 1'b0, 8'd24, 8'd12, 8'd12, 8'd6},
        '{2'd0, 6'd0,  4'hF, 1'b1, 8'd24, 8'd12, 8'd8,  8'd4},
        '{2'd0, 6'd5,  4'h5, 1'b0, 8'd24, 8'd0,  8'd12, 8'd0},
        '{2'd3, 6'd4,  4'hA, 1'b1, 8'd0,  8'd12, 8'd0,  8'd4},
        '{2'd0, 6'd63, 4'hF, 1'b1, 8'd24, 8'd12, 8'd8,  8'd4},
        '{2'd2, 6'd0,  4'h0, 1'b0, 8'd0,  8'd0,  8'd0,  8'd0}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic addr, output logic [31:0] data);
        @(negedge clk);
        rd_addr = addr;
        #1 data = rd_data;
    endtask

    task automatic count_win(input int w, output int c0, output int c1,
                             output int c2, output int c3, output int bad);
        c0 = 0; c1 = 0; c2 = 0; c3 = 0; bad = 0;
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            #1;
            c0 += int'(tick_out[0]); c1 += int'(tick_out[1]);
            c2 += int'(tick_out[2]); c3 += int'(tick_out[3]);
            if (tick_out[3:1] != 3'b0 && !tick_out[0]) bad++;
        end
    endtask

    function automatic logic [31:0] ctrl_word(input logic [1:0] src,
            input logic [5:0] div, input logic [3:0] en);
        return {4'b0, en, 10'b0, div, 2'b0, src, 4'b0};
    endfunction

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        int c0, c1, c2, c3, bad, per, deff, gap;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset state of both registers and the outputs.
        rd(1'b0, rv); check("R7", "ctrl reset", rv, 32'h0400_0000);
        rd(1'b1, rv); check("R7", "mode reset", rv, 32'h1);
        repeat (10) @(negedge clk);
        count_win(24, c0, c1, c2, c3, bad);
        check("R7", "reset out0", c0, 0);
        check("R7", "reset out1", c1, 0);
        check("R7 R4", "reset out2", c2, 8);
        check("R7", "reset out3", c3, 0);

        // Table walk: source, divisor, ratios and enables (R1..R6, R8).
        for (int v = 0; v < NV; v++) begin
            wr(1'b0, ctrl_word(VECS[v].src, VECS[v].div, VECS[v].en));
            wr(1'b1, {31'b0, VECS[v].mode});
            repeat (200) @(negedge clk);
            per  = (VECS[v].src <= 2'd1) ? 1 : int'(VECS[v].src);
            deff = (VECS[v].div == 6'd0) ? 1 : int'(VECS[v].div);
            count_win(24 * deff * per, c0, c1, c2, c3, bad);
            check(VECS[v].en[0] ? "R1 R2" : "R6", $sformatf("vec%0d out0", v), c0, VECS[v].e0);
            check(VECS[v].en[1] ? "R3" : "R6", $sformatf("vec%0d out1", v), c1, VECS[v].e1);
            check(VECS[v].en[2] ? "R4" : "R6", $sformatf("vec%0d out2", v), c2, VECS[v].e2);
            check(VECS[v].en[3] ? "R5" : "R6", $sformatf("vec%0d out3", v), c3, VECS[v].e3);
            if (VECS[v].en[0])
                check("R8", $sformatf("vec%0d align", v), bad, 0);
        end

        // R9: a divisor change applies at the boundary and restarts all counters.
        wr(1'b0, ctrl_word(2'd0, 6'd4, 4'hF));
        wr(1'b1, 32'h1);
        repeat (100) @(negedge clk);
        wr(1'b0, ctrl_word(2'd0, 6'd2, 4'hF));
        do begin @(negedge clk); #1; end while (!tick_out[0]);
        gap = 0;
        do begin @(negedge clk); #1; gap++; end while (!tick_out[0] && gap < 50);
        check("R9", "gap after change", gap, 2);
        check("R9", "first new tick", {28'b0, tick_out}, 32'hF);

        // R10: readback of defined fields only.
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, rv); check("R10", "ctrl readback", rv, 32'h0F00_3F30);
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, rv); check("R10", "mode readback 1", rv, 32'h1);
        wr(1'b1, 32'h0);
        rd(1'b1, rv); check("R10", "mode readback 0", rv, 32'h0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule